// File: doc/BRIEF.md
# PCI Interrupt Line Router

This block steers the level-sensitive interrupt pins of the devices on a PCI bus onto the sixteen inputs of a legacy interrupt controller. Every device has four interrupt pins, A to D. A fixed rotation by slot number maps each pin onto one of four shared interrupt lines. Each shared line has its own byte-wide route register. That register names the controller input the line drives, or it takes the line off the output side entirely.

Several shared lines may share one controller input. That input is then the OR of the levels of every enabled line that points at it. The merged picture sits in a registered 64-bit map with one bit per pair of controller input and shared line. The map is rebuilt from the live pin levels and the current route table on every clock. A change to a route register therefore clears the old target and drives the new one in the same update, with no stale bits left behind.

Software reaches the route registers through a 32-bit configuration port with byte enables. The four route bytes share one dword. Byte lane k holds the route for shared line k.

Top module: `pirq_router`

## Requirements
- R1: After reset every route byte reads 0x80, every shared line reports disabled with an IRQ field of 0, and all sixteen `irq_out` bits are low.
- R2: An accepted write to dword `ROUTE_DW` (default 0x18, byte address 0x60) loads byte lane k of `cfg_wdata` into the route for shared line k only where `cfg_be[k]` is 1. Bytes whose enable is 0 keep their value.
- R3: A write to any other dword index leaves all four route bytes unchanged.
- R4: An accepted read raises `cfg_rvalid` for exactly the next cycle. In that cycle `cfg_rdata` holds {route3, route2, route1, route0} for `ROUTE_DW` and zero for any other dword.
- R5: A route byte of 16 (0x10) or more disables its shared line, and that line then drives no output.
- R6: `route_en[k]` is 1 exactly when route byte k is below 16. `route_irq[4k+3:4k]` then holds the target IRQ number, and it holds 0 while the line is disabled.
- R7: Device d sits in slot s = FIRST_SLOT + d. Its pin n (A=0, B=1, C=2, D=3, at `dev_intx[4d+n]`) feeds shared line (n + s - 1) mod 4. A shared line is high when any pin that feeds it is high.
- R8: `irq_out[i]` is the OR of the levels of every enabled shared line whose route byte equals i. This allows many-to-one merging.
- R9: `irq_out` reflects the pin levels and route table that were present at the previous rising clock edge, which gives exactly one cycle of latency.
- R10: When a route byte changes, the old target falls and the new target rises in the same update, unless another enabled line still drives the old target.
- R11: `cfg_ready` is held high, so every request with `cfg_valid` high is accepted in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_valid | input | 1 | Configuration request valid |
| cfg_ready | output | 1 | Request accepted (always high) |
| cfg_write | input | 1 | 1 = write, 0 = read |
| cfg_dw_addr | input | 6 | Dword index of the configuration access |
| cfg_be | input | 4 | Byte enables for writes |
| cfg_wdata | input | 32 | Write data |
| cfg_rvalid | output | 1 | Read data valid, one cycle after the read is accepted |
| cfg_rdata | output | 32 | Read data |
| dev_intx | input | 4*NUM_SLOTS | Device pin levels, 4 per device |
| route_en | output | 4 | Per-line route enabled |
| route_irq | output | 16 | Per-line target IRQ, 4 bits each |
| irq_out | output | 16 | Levels toward the interrupt controller |

## Verification
The assertions take every input to be known from the end of reset. They also take any request to be a single-cycle pulse of `cfg_valid` with stable address, enables and data while it is high, because the routes, the read response and the latency rules are stated per accepted request.

The stimulus meets these conditions by driving all inputs at falling edges from reset onward. It raises `cfg_valid` for one cycle at a time and changes pin levels only at falling edges. The random route values are weighted toward legal IRQ numbers and toward the 0x10 and 0x80 disable codes.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
  localparam int NUM_PIRQ  = 4;
  localparam int NUM_IRQ   = 16;
  localparam int IRQ_W     = $clog2(NUM_IRQ);
  localparam int PIRQ_W    = $clog2(NUM_PIRQ);
  localparam int MAP_W     = NUM_IRQ * NUM_PIRQ;
  localparam logic [7:0] ROUTE_RESET = 8'h80;

  typedef logic [7:0] route_byte_t;

  // A byte below NUM_IRQ names a live target; anything else parks the line.
  function automatic logic route_live(input route_byte_t b);
    return b < 8'(NUM_IRQ);
  endfunction

  // Shared line fed by pin n of the device in slot s: (n + s - 1) mod 4.
  function automatic logic [PIRQ_W-1:0] rotate_pin(input int unsigned n,
                                                   input int unsigned s);
    return PIRQ_W'((n + s + NUM_PIRQ - 1) % NUM_PIRQ);
  endfunction
endpackage

// File: rtl/pirq_route_regs.sv
module pirq_route_regs
  import pirq_pkg::*;
#(
  parameter logic [5:0] ROUTE_DW = 6'h18
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfg_valid,
  input  logic                        cfg_write,
  input  logic [5:0]                  cfg_dw_addr,
  input  logic [NUM_PIRQ-1:0]         cfg_be,
  input  logic [8*NUM_PIRQ-1:0]       cfg_wdata,
  output logic                        cfg_rvalid,
  output logic [8*NUM_PIRQ-1:0]       cfg_rdata,
  output route_byte_t                 route_q [NUM_PIRQ],
  output logic [NUM_PIRQ-1:0]         route_en,
  output logic [NUM_PIRQ*IRQ_W-1:0]   route_irq
);
  logic hit;
  logic wr_acc;
  logic rd_acc;
  logic [8*NUM_PIRQ-1:0] packed_routes;

  assign hit    = (cfg_dw_addr == ROUTE_DW);
  assign wr_acc = cfg_valid && cfg_write && hit;
  assign rd_acc = cfg_valid && !cfg_write;

  for (genvar k = 0; k < NUM_PIRQ; k++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        route_q[k] <= ROUTE_RESET;
      end else if (wr_acc && cfg_be[k]) begin
        route_q[k] <= cfg_wdata[8*k +: 8];
      end
    end

    assign packed_routes[8*k +: 8]       = route_q[k];
    assign route_en[k]                   = route_live(route_q[k]);
    assign route_irq[IRQ_W*k +: IRQ_W]   = route_en[k] ? route_q[k][IRQ_W-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_rvalid <= 1'b0;
      cfg_rdata  <= '0;
    end else begin
      cfg_rvalid <= rd_acc;
      if (rd_acc) begin
        cfg_rdata <= hit ? packed_routes : '0;
      end
    end
  end
endmodule

// File: rtl/pirq_swizzle.sv
module pirq_swizzle
  import pirq_pkg::*;
#(
  parameter int NUM_SLOTS  = 4,
  parameter int FIRST_SLOT = 1
) (
  input  logic [NUM_PIRQ*NUM_SLOTS-1:0] dev_intx,
  output logic [NUM_PIRQ-1:0]           pirq_lvl
);
  localparam int PINS = NUM_PIRQ * NUM_SLOTS;

  // Per-pin one-hot steering toward its shared line.
  logic [NUM_PIRQ-1:0] steer [PINS];

  for (genvar d = 0; d < NUM_SLOTS; d++) begin : g_dev
    for (genvar n = 0; n < NUM_PIRQ; n++) begin : g_pin
      localparam logic [PIRQ_W-1:0] LINE = rotate_pin(n, FIRST_SLOT + d);
      always_comb begin
        steer[d*NUM_PIRQ + n]       = '0;
        steer[d*NUM_PIRQ + n][LINE] = dev_intx[d*NUM_PIRQ + n];
      end
    end
  end

  always_comb begin
    pirq_lvl = '0;
    for (int i = 0; i < PINS; i++) begin
      pirq_lvl = pirq_lvl | steer[i];
    end
  end
endmodule

// File: rtl/pirq_level_map.sv
module pirq_level_map
  import pirq_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_PIRQ-1:0]       pirq_lvl,
  input  logic [NUM_PIRQ-1:0]       route_en,
  input  logic [NUM_PIRQ*IRQ_W-1:0] route_irq,
  output logic [NUM_IRQ-1:0]        irq_out
);
  // Bit (irq*NUM_PIRQ + line) is set when line is live, aimed at irq, and high.
  logic [MAP_W-1:0] map_d;
  logic [MAP_W-1:0] map_q;

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
    for (genvar p = 0; p < NUM_PIRQ; p++) begin : g_line
      assign map_d[i*NUM_PIRQ + p] = route_en[p] && pirq_lvl[p] &&
                                     (route_irq[IRQ_W*p +: IRQ_W] == IRQ_W'(i));
    end
    assign irq_out[i] = |map_q[i*NUM_PIRQ +: NUM_PIRQ];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) map_q <= '0;
    else        map_q <= map_d;
  end
endmodule

// File: rtl/pirq_router.sv
module pirq_router
  import pirq_pkg::*;
#(
  parameter int         NUM_SLOTS  = 4,
  parameter int         FIRST_SLOT = 1,
  parameter logic [5:0] ROUTE_DW   = 6'h18
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_valid,
  output logic                          cfg_ready,
  input  logic                          cfg_write,
  input  logic [5:0]                    cfg_dw_addr,
  input  logic [3:0]                    cfg_be,
  input  logic [31:0]                   cfg_wdata,
  output logic                          cfg_rvalid,
  output logic [31:0]                   cfg_rdata,
  input  logic [4*NUM_SLOTS-1:0]        dev_intx,
  output logic [3:0]                    route_en,
  output logic [15:0]                   route_irq,
  output logic [15:0]                   irq_out
);
  route_byte_t         route_q [NUM_PIRQ];
  logic [NUM_PIRQ-1:0] pirq_lvl;

  assign cfg_ready = 1'b1;

  pirq_route_regs #(.ROUTE_DW(ROUTE_DW)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_valid  (cfg_valid),
    .cfg_write  (cfg_write),
    .cfg_dw_addr(cfg_dw_addr),
    .cfg_be     (cfg_be),
    .cfg_wdata  (cfg_wdata),
    .cfg_rvalid (cfg_rvalid),
    .cfg_rdata  (cfg_rdata),
    .route_q    (route_q),
    .route_en   (route_en),
    .route_irq  (route_irq)
  );

  pirq_swizzle #(.NUM_SLOTS(NUM_SLOTS), .FIRST_SLOT(FIRST_SLOT)) u_swz (
    .dev_intx(dev_intx),
    .pirq_lvl(pirq_lvl)
  );

  pirq_level_map u_map (
    .clk      (clk),
    .rst_n    (rst_n),
    .pirq_lvl (pirq_lvl),
    .route_en (route_en),
    .route_irq(route_irq),
    .irq_out  (irq_out)
  );
endmodule

// File: rtl/pirq_router_chk.sv
module pirq_router_chk #(
  parameter logic [5:0] ROUTE_DW = 6'h18
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_valid,
  input logic        cfg_write,
  input logic [5:0]  cfg_dw_addr,
  input logic [3:0]  cfg_be,
  input logic        cfg_rvalid,
  input logic [3:0]  route_en,
  input logic [15:0] route_irq,
  input logic [3:0]  pirq_lvl,
  input logic [15:0] irq_out
);
  logic [15:0] live_targets;
  logic [15:0] want_now;

  always_comb begin
    live_targets = '0;
    want_now     = '0;
    for (int p = 0; p < 4; p++) begin
      if (route_en[p]) begin
        live_targets[route_irq[4*p +: 4]] = 1'b1;
        if (pirq_lvl[p]) want_now[route_irq[4*p +: 4]] = 1'b1;
      end
    end
  end

  // R4: read acceptance yields exactly one rvalid cycle
  p_rvalid_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && !cfg_write) |=> cfg_rvalid);
  p_rvalid_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_valid && !cfg_write) |=> !cfg_rvalid);

  // R3: foreign-dword writes do not touch routes
  p_foreign_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && cfg_write && cfg_dw_addr != ROUTE_DW) |=>
      ($stable(route_en) && $stable(route_irq)));

  // R2: a write with no enabled lane leaves routes alone
  p_no_lane_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && cfg_write && cfg_be == 4'b0000) |=>
      ($stable(route_en) && $stable(route_irq)));

  // R5, R8: no output rises outside the set of live targets
  p_only_live_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((irq_out & ~$past(live_targets)) == 16'h0000));

  // R9: outputs follow line levels and routes after one clock
  p_one_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_out == $past(want_now)));

  // R6: a disabled line reports a zero target field
  p_dis_field_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !route_en[0] |-> (route_irq[3:0] == 4'h0));
endmodule

bind pirq_router pirq_router_chk #(.ROUTE_DW(ROUTE_DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_valid  (cfg_valid),
  .cfg_write  (cfg_write),
  .cfg_dw_addr(cfg_dw_addr),
  .cfg_be     (cfg_be),
  .cfg_rvalid (cfg_rvalid),
  .route_en   (route_en),
  .route_irq  (route_irq),
  .pirq_lvl   (pirq_lvl),
  .irq_out    (irq_out)
);

// File: tb/pirq_router_bench.sv
module pirq_router_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NSLOT      = 4;
  localparam int FSLOT      = 1;
  localparam logic [5:0] RDW = 6'h18;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_valid = 1'b0;
  logic        cfg_ready;
  logic        cfg_write = 1'b0;
  logic [5:0]  cfg_dw_addr = '0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic        cfg_rvalid;
  logic [31:0] cfg_rdata;
  logic [4*NSLOT-1:0] dev_intx = '0;
  logic [3:0]  route_en;
  logic [15:0] route_irq;
  logic [15:0] irq_out;

  int checks = 0;
  int errors = 0;
  logic [7:0] m_route [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  pirq_router #(.NUM_SLOTS(NSLOT), .FIRST_SLOT(FSLOT), .ROUTE_DW(RDW)) u_pirq_router (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_ready(cfg_ready),
    .cfg_write(cfg_write), .cfg_dw_addr(cfg_dw_addr), .cfg_be(cfg_be),
    .cfg_wdata(cfg_wdata), .cfg_rvalid(cfg_rvalid), .cfg_rdata(cfg_rdata),
    .dev_intx(dev_intx), .route_en(route_en), .route_irq(route_irq),
    .irq_out(irq_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] line_levels(input logic [4*NSLOT-1:0] pins);
    logic [3:0] l = '0;
    for (int d = 0; d < NSLOT; d++)
      for (int n = 0; n < 4; n++)
        if (pins[4*d+n]) l[(n + FSLOT + d + 3) % 4] = 1'b1;
    return l;
  endfunction

  function automatic logic [15:0] want_irq(input logic [4*NSLOT-1:0] pins);
    logic [15:0] o = '0;
    logic [3:0] l = line_levels(pins);
    for (int p = 0; p < 4; p++)
      if (m_route[p] < 8'd16 && l[p]) o[m_route[p][3:0]] = 1'b1;
    return o;
  endfunction

  function automatic logic [3:0] want_en();
    logic [3:0] e;
    for (int p = 0; p < 4; p++) e[p] = m_route[p] < 8'd16;
    return e;
  endfunction

  function automatic logic [15:0] want_field();
    logic [15:0] f = '0;
    for (int p = 0; p < 4; p++)
      if (m_route[p] < 8'd16) f[4*p +: 4] = m_route[p][3:0];
    return f;
  endfunction

  task automatic cfg_wr(input logic [5:0] a, input logic [3:0] be, input logic [31:0] v);
    @(negedge clk);
    cfg_valid = 1'b1; cfg_write = 1'b1; cfg_dw_addr = a; cfg_be = be; cfg_wdata = v;
    @(negedge clk);
    cfg_valid = 1'b0; cfg_write = 1'b0;
    if (a == RDW)
      for (int k = 0; k < 4; k++) if (be[k]) m_route[k] = v[8*k +: 8];
    @(negedge clk);
  endtask

  task automatic cfg_rd(input logic [5:0] a, input string req, input logic [31:0] exp);
    @(negedge clk);
    cfg_valid = 1'b1; cfg_write = 1'b0; cfg_dw_addr = a;
    @(negedge clk);
    cfg_valid = 1'b0;
    chk({req, " rvalid"}, 32'(cfg_rvalid), 32'd1);
    chk({req, " rdata"}, cfg_rdata, exp);
    @(negedge clk);
    chk({req, " rvalid drop"}, 32'(cfg_rvalid), 32'd0);
  endtask

  task automatic set_pins(input logic [4*NSLOT-1:0] v);
    @(negedge clk);
    dev_intx = v;
    @(negedge clk);
  endtask

  function automatic logic [31:0] packed_model();
    return {m_route[3], m_route[2], m_route[1], m_route[0]};
  endfunction

  task automatic check_all(input string req);
    chk({req, " irq_out"}, 32'(irq_out), 32'(want_irq(dev_intx)));
    chk({req, " route_en"}, 32'(route_en), 32'(want_en()));
    chk({req, " route_irq"}, 32'(route_irq), 32'(want_field()));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    seed = 32'd20240611;
    void'($urandom(seed));
    for (int k = 0; k < 4; k++) m_route[k] = 8'h80;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1 irq_out", 32'(irq_out), 32'h0);
    chk("R1 route_en", 32'(route_en), 32'h0);
    chk("R1 route_irq", 32'(route_irq), 32'h0);
    chk("R11 ready", 32'(cfg_ready), 32'd1);
    cfg_rd(RDW, "R1 R4 reset read", 32'h80808080);

    // R5: all lines disabled, pins high -> nothing drives
    set_pins('1);
    chk("R5 disabled lines silent", 32'(irq_out), 32'h0);

    // R8: many-to-one, all lines onto IRQ 5
    cfg_wr(RDW, 4'hF, 32'h05050505);
    check_all("R8 merge");
    chk("R8 only irq5", 32'(irq_out), 32'h0020);

    // R7: device 0 (slot 1) pin A -> line 0; route lines apart
    cfg_wr(RDW, 4'hF, 32'h0B0A0903);
    set_pins(16'h0001);
    chk("R7 d0 pinA -> line0 irq3", 32'(irq_out), 32'h0008);
    // device 3 (slot 4) pin B -> line (1+3)%4 = 0
    set_pins(16'h2000);
    chk("R7 d3 pinB -> line0", 32'(irq_out), 32'h0008);
    // device 1 (slot 2) pin A -> line 1 -> irq 9
    set_pins(16'h0010);
    chk("R7 d1 pinA -> line1 irq9", 32'(irq_out), 32'h0200);

    // R9: output changes exactly one clock after pin change
    @(negedge clk);
    dev_intx = 16'h0001;
    chk("R9 before edge", 32'(irq_out), 32'h0200);
    @(negedge clk);
    chk("R9 after one edge", 32'(irq_out), 32'h0008);

    // R2: byte-enable partial write (lane 2 only)
    cfg_wr(RDW, 4'b0100, 32'hAA0FBBCC);
    check_all("R2 lane2 only");
    cfg_rd(RDW, "R2 R4 readback", 32'h0B0F0903);

    // R3: foreign dword write ignored; foreign read returns zero
    cfg_wr(6'h19, 4'hF, 32'h01010101);
    cfg_rd(RDW, "R3 routes kept", 32'h0B0F0903);
    cfg_rd(6'h00, "R4 foreign read zero", 32'h0);

    // R5/R6 boundary: 0x0F enabled (irq 15), 0x10 disabled
    cfg_wr(RDW, 4'b0011, 32'h0000100F);
    set_pins(16'h0003);
    check_all("R5 R6 boundary");
    chk("R6 line0 en", 32'(route_en[0]), 32'd1);
    chk("R5 line1 off", 32'(route_en[1]), 32'd0);

    // R10: move a live line from one target to another
    set_pins(16'h0001);
    chk("R10 before move", 32'(irq_out), 32'h8000);
    cfg_wr(RDW, 4'b0001, 32'h00000004);
    chk("R10 after move", 32'(irq_out), 32'h0010);

    // Random mix of route writes and pin changes
    for (int it = 0; it < 300; it++) begin
      int unsigned sel = $urandom % 4;
      if (sel == 0) begin
        logic [31:0] v;
        for (int k = 0; k < 4; k++) begin
          int unsigned c = $urandom % 8;
          v[8*k +: 8] = (c < 5) ? 8'($urandom % 16) : (c == 5) ? 8'h10 :
                        (c == 6) ? 8'h80 : 8'($urandom);
        end
        cfg_wr(($urandom % 4 == 0) ? 6'($urandom) : RDW, 4'($urandom), v);
        check_all("R2 R8 R10 random write");
      end else if (sel == 1) begin
        cfg_rd(RDW, "R4 random read", packed_model());
      end else begin
        set_pins(16'($urandom) & 16'($urandom));
        check_all("R7 R8 R9 random pins");
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule